// File: doc/BRIEF.md
# Multi-Chain Partial-Sum Return Network

This block carries finished partial sums from an array of processing elements back to the global buffer. The elements are split into several chains that work side by side. Each chain is a line of small single-entry switches, one per element, and the last switch of a chain drives that chain's own buffer write port. A word therefore moves one hop per cycle towards the buffer. The aggregate return rate is one word per chain per cycle.

Every switch except the one at the far end of a chain has two sources: its own element and the switch upstream of it. A two-way round-robin arbiter picks between them. The switch at the far end has only its element, so it has no arbiter. Paths never change. Traffic is held back only by an on/off signal that each switch returns to its element and, through its take decision, to its upstream neighbour. No credit counters are kept. Each word is tagged with the index of the element that produced it, so the buffer side can place it.

Top module: `gather_net`

## Requirements
- R1: After reset every buffer-side valid is low and every element-side `pe_on` is high.
- R2: The tag on a word equals chain × PER_CHAIN + position, where position 0 is the element farthest from the buffer and position PER_CHAIN−1 is the nearest. A chain's port carries only its own elements' tags.
- R3: While a chain's buffer valid is high and its ready is low, the valid, data and tag of that port hold unchanged into the next cycle.
- R4: Every word accepted from an element reaches the buffer exactly once, with its data unchanged, and words from one element arrive in the order they were accepted.
- R5: A word moves from an element only in a cycle where both its valid and `pe_on` are high. `pe_on` is low whenever that element's switch register is occupied and its word is not leaving in the same cycle.
- R6: At positions above 0, a switch grants either its element or its upstream neighbour in a cycle, never both. When both request and there is room, the winner is the side that did not win that switch's most recent grant. The upstream side wins first after reset.
- R7: The position-0 switch has no arbiter: its `pe_on` is high whenever its register is empty or its word is leaving that cycle.
- R8: Chains are independent. A chain whose ready stays low blocks only its own elements and leaves the delivery rate of the other chains unchanged.
- R9: With ready held high and every element of a chain always offering words, that chain delivers one word every cycle.
- R10: In an otherwise idle chain with ready high, a word accepted from position k at the end of cycle t is presented at the buffer port in cycle t + PER_CHAIN − k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pe_valid | input | NCHAIN*PER_CHAIN | Element offers a word; bit chain*PER_CHAIN+position |
| pe_data | input | NCHAIN*PER_CHAIN*DW | Element words, DW bits per element in the same order |
| pe_on | output | NCHAIN*PER_CHAIN | Element's switch will take an offered word this cycle |
| buf_valid | output | NCHAIN | Chain presents a word to the buffer |
| buf_data | output | NCHAIN*DW | Word per chain |
| buf_tag | output | NCHAIN*TW | Source element index per chain, TW = clog2(NCHAIN*PER_CHAIN) |
| buf_ready | input | NCHAIN | Buffer write port of the chain accepts the word |

## Verification
The assertions check on every cycle that a held switch word is never lost while blocked, that `pe_on` falls whenever a switch is full and stuck, and that no switch grants twice. They also check that a contested grant alternates, that the head switch stays open when it has room, that a stalled buffer port is stable, and that each port carries only its own chain's tags. Only the bench's scenarios can show end-to-end properties. These are exactly-once, in-order delivery per element, the per-hop latency from each position, full-rate delivery when all elements stream, and the unchanged rate of the free chains while one chain is stalled.

// File: rtl/gather_pkg.sv
package gather_pkg;

  // Flat element index of a chain position.
  function automatic int unsigned pe_slot(int unsigned chain, int unsigned pos,
                                          int unsigned per_chain);
    return chain * per_chain + pos;
  endfunction

  // A single-entry register can load when empty or when its word leaves now.
  function automatic logic room_for_word(logic held, logic leaving);
    return !held || leaving;
  endfunction

  // Two-way round robin: the local element wins when it requests and either
  // the upstream side is idle or the local side holds the preference.
  function automatic logic grant_local(logic loc_req, logic up_req, logic prefer_local);
    return loc_req && (!up_req || prefer_local);
  endfunction

endpackage

// File: rtl/gather_switch.sv
module gather_switch
  import gather_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4,
  parameter bit HAS_UP = 1'b1,
  parameter logic [TW-1:0] SRC_TAG = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_valid,
  input  logic [DW-1:0] loc_data,
  output logic          loc_on,
  output logic          loc_take,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  input  logic [TW-1:0] up_tag,
  output logic          up_take,
  input  logic          down_take,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [TW-1:0] out_tag,
  output logic          room
);

  logic          held;
  logic [DW-1:0] data_q;
  logic [TW-1:0] tag_q;

  assign room = room_for_word(held, held && down_take);

  generate
    if (HAS_UP) begin : g_arb
      logic pref_local;

      assign loc_on  = room && (!up_valid || pref_local);
      assign up_take = room && up_valid && !grant_local(loc_valid, up_valid, pref_local);

      always_ff @(posedge clk) begin
        if (rst)           pref_local <= 1'b0;
        else if (loc_take) pref_local <= 1'b0;
        else if (up_take)  pref_local <= 1'b1;
      end
    end else begin : g_head
      logic unused_up;
      assign unused_up = ^{up_valid, up_data, up_tag};
      assign loc_on    = room;
      assign up_take   = 1'b0;
    end
  endgenerate

  assign loc_take = loc_valid && loc_on;

  always_ff @(posedge clk) begin
    if (rst)                       held <= 1'b0;
    else if (loc_take || up_take)  held <= 1'b1;
    else if (down_take)            held <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      tag_q  <= '0;
    end else if (loc_take) begin
      data_q <= loc_data;
      tag_q  <= SRC_TAG;
    end else if (up_take) begin
      data_q <= up_data;
      tag_q  <= up_tag;
    end
  end

  assign out_valid = held;
  assign out_data  = data_q;
  assign out_tag   = tag_q;

endmodule

// File: rtl/gather_chain.sv
module gather_chain
  import gather_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int PER_CHAIN = 4,
  parameter int CHAIN_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PER_CHAIN-1:0]    pe_valid,
  input  logic [PER_CHAIN*DW-1:0] pe_data,
  output logic [PER_CHAIN-1:0]    pe_on,
  output logic                   buf_valid,
  output logic [DW-1:0]          buf_data,
  output logic [TW-1:0]          buf_tag,
  input  logic                   buf_ready,
  output logic [PER_CHAIN-1:0]    obs_full,
  output logic [PER_CHAIN-1:0]    obs_pop,
  output logic [PER_CHAIN-1:0]    obs_loc_take,
  output logic [PER_CHAIN-1:0]    obs_up_take,
  output logic [PER_CHAIN-1:0]    obs_room
);

  localparam int LAST = PER_CHAIN - 1;

  logic [PER_CHAIN-1:0]    hop_valid;
  logic [PER_CHAIN*DW-1:0] hop_data;
  logic [PER_CHAIN*TW-1:0] hop_tag;
  logic [PER_CHAIN-1:0]    hop_up_take;
  logic [PER_CHAIN-1:0]    hop_down_take;

  for (genvar k = 0; k < PER_CHAIN; k++) begin : g_hop
    localparam int unsigned SLOT = pe_slot(CHAIN_ID, k, PER_CHAIN);
    localparam logic [TW-1:0] TAGV = TW'(SLOT);

    logic          in_valid;
    logic [DW-1:0] in_data;
    logic [TW-1:0] in_tag;

    if (k == 0) begin : g_src_none
      assign in_valid = 1'b0;
      assign in_data  = '0;
      assign in_tag   = '0;
    end else begin : g_src_prev
      assign in_valid = hop_valid[k-1];
      assign in_data  = hop_data[(k-1)*DW +: DW];
      assign in_tag   = hop_tag[(k-1)*TW +: TW];
    end

    if (k == LAST) begin : g_sink_buf
      assign hop_down_take[k] = buf_ready;
    end else begin : g_sink_next
      assign hop_down_take[k] = hop_up_take[k+1];
    end

    gather_switch #(
      .DW(DW), .TW(TW), .HAS_UP(k != 0), .SRC_TAG(TAGV)
    ) u_sw (
      .clk(clk), .rst(rst),
      .loc_valid(pe_valid[k]), .loc_data(pe_data[k*DW +: DW]),
      .loc_on(pe_on[k]), .loc_take(obs_loc_take[k]),
      .up_valid(in_valid), .up_data(in_data), .up_tag(in_tag),
      .up_take(hop_up_take[k]),
      .down_take(hop_down_take[k]),
      .out_valid(hop_valid[k]), .out_data(hop_data[k*DW +: DW]),
      .out_tag(hop_tag[k*TW +: TW]),
      .room(obs_room[k])
    );

    assign obs_pop[k] = hop_valid[k] && hop_down_take[k];
  end

  assign obs_full    = hop_valid;
  assign obs_up_take = hop_up_take;
  assign buf_valid   = hop_valid[LAST];
  assign buf_data    = hop_data[LAST*DW +: DW];
  assign buf_tag     = hop_tag[LAST*TW +: TW];

endmodule

// File: rtl/gather_net.sv
module gather_net #(
  parameter int NCHAIN = 4,
  parameter int PER_CHAIN = 4,
  parameter int DW = 16,
  localparam int NPE = NCHAIN * PER_CHAIN,
  localparam int TW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPE-1:0]      pe_valid,
  input  logic [NPE*DW-1:0]   pe_data,
  output logic [NPE-1:0]      pe_on,
  output logic [NCHAIN-1:0]   buf_valid,
  output logic [NCHAIN*DW-1:0] buf_data,
  output logic [NCHAIN*TW-1:0] buf_tag,
  input  logic [NCHAIN-1:0]   buf_ready
);

  logic [NPE-1:0] sw_full;
  logic [NPE-1:0] sw_pop;
  logic [NPE-1:0] sw_loc_take;
  logic [NPE-1:0] sw_up_take;
  logic [NPE-1:0] sw_room;

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    gather_chain #(
      .DW(DW), .TW(TW), .PER_CHAIN(PER_CHAIN), .CHAIN_ID(c)
    ) u_chain (
      .clk(clk), .rst(rst),
      .pe_valid(pe_valid[c*PER_CHAIN +: PER_CHAIN]),
      .pe_data(pe_data[c*PER_CHAIN*DW +: PER_CHAIN*DW]),
      .pe_on(pe_on[c*PER_CHAIN +: PER_CHAIN]),
      .buf_valid(buf_valid[c]),
      .buf_data(buf_data[c*DW +: DW]),
      .buf_tag(buf_tag[c*TW +: TW]),
      .buf_ready(buf_ready[c]),
      .obs_full(sw_full[c*PER_CHAIN +: PER_CHAIN]),
      .obs_pop(sw_pop[c*PER_CHAIN +: PER_CHAIN]),
      .obs_loc_take(sw_loc_take[c*PER_CHAIN +: PER_CHAIN]),
      .obs_up_take(sw_up_take[c*PER_CHAIN +: PER_CHAIN]),
      .obs_room(sw_room[c*PER_CHAIN +: PER_CHAIN])
    );
  end

endmodule

// File: rtl/gather_net_chk.sv
module gather_net_chk #(
  parameter int NCHAIN = 4,
  parameter int PER_CHAIN = 4,
  parameter int DW = 16,
  localparam int NPE = NCHAIN * PER_CHAIN,
  localparam int TW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NPE-1:0]       pe_valid,
  input logic [NPE-1:0]       pe_on,
  input logic [NCHAIN-1:0]    buf_valid,
  input logic [NCHAIN-1:0]    buf_ready,
  input logic [NCHAIN*DW-1:0] buf_data,
  input logic [NCHAIN*TW-1:0] buf_tag,
  input logic [NPE-1:0]       sw_full,
  input logic [NPE-1:0]       sw_pop,
  input logic [NPE-1:0]       sw_loc_take,
  input logic [NPE-1:0]       sw_up_take,
  input logic [NPE-1:0]       sw_room
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  for (genvar i = 0; i < NPE; i++) begin : g_sw
    localparam int POS = i % PER_CHAIN;

    assert_word_kept_R4: assert property (@(posedge clk) disable iff (rst)
      sw_full[i] && !sw_pop[i] |=> sw_full[i]);

    assert_off_when_stuck_R5: assert property (@(posedge clk) disable iff (rst)
      sw_full[i] && !sw_pop[i] |-> !pe_on[i]);

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
      !(sw_loc_take[i] && sw_up_take[i]));

    if (POS == 0) begin : g_head
      assert_head_open_R7: assert property (@(posedge clk) disable iff (rst)
        !sw_full[i] |-> pe_on[i]);
    end else begin : g_mid
      assert_rr_alternate_R6: assert property (@(posedge clk) disable iff (rst)
        armed && sw_room[i] && pe_valid[i] && sw_full[i-1] && $past(sw_loc_take[i])
        |-> sw_up_take[i]);
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_port
    assert_port_stable_R3: assert property (@(posedge clk) disable iff (rst)
      buf_valid[c] && !buf_ready[c] |=> buf_valid[c]
        && $stable(buf_data[c*DW +: DW]) && $stable(buf_tag[c*TW +: TW]));

    assert_tag_in_chain_R2: assert property (@(posedge clk) disable iff (rst)
      buf_valid[c] |-> (int'(buf_tag[c*TW +: TW]) / PER_CHAIN) == c);
  end

endmodule

bind gather_net gather_net_chk #(
  .NCHAIN(NCHAIN), .PER_CHAIN(PER_CHAIN), .DW(DW)
) u_chk (.*);

// File: tb/tb_gather_net.sv
module tb_gather_net;

  localparam int NCHAIN = 4;
  localparam int P = 4;
  localparam int DW = 16;
  localparam int NPE = NCHAIN * P;
  localparam int TW = $clog2(NPE);
  localparam int CLK_PERIOD = 10;

  logic                 clk;
  logic                 rst;
  logic [NPE-1:0]       pe_valid;
  logic [NPE*DW-1:0]    pe_data;
  logic [NPE-1:0]       pe_on;
  logic [NCHAIN-1:0]    buf_valid;
  logic [NCHAIN*DW-1:0] buf_data;
  logic [NCHAIN*TW-1:0] buf_tag;
  logic [NCHAIN-1:0]    buf_ready;

  gather_net #(.NCHAIN(NCHAIN), .PER_CHAIN(P), .DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp, n_bad, cyc, rr_bad;
  int remaining[NPE], seq_tx[NPE], seq_rx[NPE], take_cyc[NPE], last_lat[NPE];
  int deliv[NCHAIN], prev_tag[NCHAIN];
  bit m_full[NPE], m_pref_loc[NPE];
  int m_tag[NPE], m_data[NPE];
  logic [NCHAIN-1:0] rdy_set;
  bit rdy_rand, rr_watch, finished;
  logic [15:0] lfsr;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock of stimulus plus the behavioural reference model.
  task automatic cycle();
    bit on_m[NPE], pt[NPE], ut[NPE], pop_m[NPE];
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    buf_ready = rdy_rand ? (rdy_set & lfsr[NCHAIN-1:0]) : rdy_set;
    for (int i = 0; i < NPE; i++) begin
      pe_valid[i] = remaining[i] > 0;
      pe_data[i*DW +: DW] = DW'((i << 8) | (seq_tx[i] & 255));
    end
    #1;
    // A word in a register leaves when its receiver takes it; a register
    // takes a word when empty or emptying; contests go to the side that
    // lost the previous grant.
    for (int c = 0; c < NCHAIN; c++) begin
      for (int k = P - 1; k >= 0; k--) begin
        int i = c * P + k;
        bit leave, space, up_req, up_first;
        leave = (k == P - 1) ? buf_ready[c] : ut[i + 1];
        pop_m[i] = m_full[i] && leave;
        space = !m_full[i] || pop_m[i];
        if (k == 0) begin
          on_m[i] = space;
          ut[i] = 1'b0;
        end else begin
          up_req = m_full[i - 1];
          up_first = !m_pref_loc[i];
          on_m[i] = space && !(up_req && up_first);
          ut[i] = space && up_req && !(pe_valid[i] && !up_first);
        end
        pt[i] = pe_valid[i] && on_m[i];
      end
    end
    for (int i = 0; i < NPE; i++)
      check(pe_on[i] === on_m[i], "R5 R6 R7 pe_on", int'(pe_on[i]), int'(on_m[i]));
    for (int c = 0; c < NCHAIN; c++) begin
      int l = c * P + P - 1;
      check(buf_valid[c] === m_full[l], "R3 R8 buf_valid", int'(buf_valid[c]), int'(m_full[l]));
      if (m_full[l]) begin
        check(int'(buf_tag[c*TW +: TW]) == m_tag[l], "R2 buf_tag",
              int'(buf_tag[c*TW +: TW]), m_tag[l]);
        check(int'(buf_data[c*DW +: DW]) == m_data[l], "R4 buf_data",
              int'(buf_data[c*DW +: DW]), m_data[l]);
      end
      if (m_full[l] && buf_ready[c]) begin
        int tg = int'(buf_tag[c*TW +: TW]);
        int expd = (tg << 8) | (seq_rx[tg] & 255);
        check(int'(buf_data[c*DW +: DW]) == expd, "R4 per-element order",
              int'(buf_data[c*DW +: DW]), expd);
        seq_rx[tg]++;
        deliv[c]++;
        last_lat[tg] = cyc - take_cyc[tg];
        if (rr_watch && c == 0 && ((tg == P - 1) == (prev_tag[0] == P - 1))) rr_bad++;
        prev_tag[c] = tg;
      end
    end
    for (int c = 0; c < NCHAIN; c++) begin
      for (int k = P - 1; k >= 0; k--) begin
        int i = c * P + k;
        if (pt[i]) begin
          m_full[i] = 1'b1; m_tag[i] = i; m_data[i] = int'(pe_data[i*DW +: DW]);
          m_pref_loc[i] = 1'b0;
          remaining[i]--; seq_tx[i]++; take_cyc[i] = cyc;
        end else if (ut[i]) begin
          m_full[i] = 1'b1; m_tag[i] = m_tag[i - 1]; m_data[i] = m_data[i - 1];
          m_pref_loc[i] = 1'b1;
        end else if (pop_m[i]) begin
          m_full[i] = 1'b0;
        end
      end
    end
    cyc++;
  endtask

  task automatic run(int n);
    for (int j = 0; j < n; j++) cycle();
  endtask

  task automatic clear_deliv();
    for (int c = 0; c < NCHAIN; c++) deliv[c] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog R4: actual %0d expected %0d (run did not complete)", 0, 1);
    report();
  end

  initial begin
    lfsr = 16'hACE1;
    rdy_set = '0; rdy_rand = 1'b0; rr_watch = 1'b0;
    for (int i = 0; i < NPE; i++) begin
      remaining[i] = 0; seq_tx[i] = 0; seq_rx[i] = 0; m_full[i] = 1'b0;
      m_pref_loc[i] = 1'b0; m_tag[i] = 0; m_data[i] = 0; take_cyc[i] = 0; last_lat[i] = -1;
    end
    for (int c = 0; c < NCHAIN; c++) prev_tag[c] = -1;
    rst = 1'b1; pe_valid = '0; pe_data = '0; buf_ready = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check(buf_valid == '0, "R1 buf_valid after reset", int'(buf_valid), 0);
    check(pe_on == '1, "R1 pe_on after reset", int'(pe_on), (1 << NPE) - 1);

    // R10 and R2: lone word latency from every position of chain 0
    rdy_set = '1;
    for (int k = 0; k < P; k++) begin
      remaining[k] = 1;
      run(P + 3);
      check(last_lat[k] == P - k, "R10 latency", last_lat[k], P - k);
      check(prev_tag[0] == k, "R2 tag of chain 0", prev_tag[0], k);
    end
    remaining[2 * P + 1] = 1;
    run(P + 3);
    check(prev_tag[2] == 2 * P + 1, "R2 tag of chain 2", prev_tag[2], 2 * P + 1);
    check(last_lat[2 * P + 1] == P - 1, "R10 latency chain 2", last_lat[2 * P + 1], P - 1);

    // R9 and R6: all elements stream with ready high
    for (int i = 0; i < NPE; i++) remaining[i] = 200;
    run(20);
    clear_deliv();
    rr_watch = 1'b1; rr_bad = 0; prev_tag[0] = -1;
    cycle();
    rr_bad = 0;
    clear_deliv();
    run(20);
    rr_watch = 1'b0;
    for (int c = 0; c < NCHAIN; c++)
      check(deliv[c] == 20, "R9 full-rate delivery", deliv[c], 20);
    check(rr_bad == 0, "R6 nearest element alternates with upstream", rr_bad, 0);

    // R8 and R5: chain 1 stalled, others keep flowing
    rdy_set = 4'b1101;
    run(10);
    clear_deliv();
    run(20);
    check(deliv[0] == 20, "R8 free chain rate", deliv[0], 20);
    check(deliv[1] == 0, "R8 stalled chain delivers nothing", deliv[1], 0);
    check(pe_on[P +: P] == '0, "R5 stalled chain all off", int'(pe_on[P +: P]), 0);

    // R3 and R4: random back-pressure on every chain
    rdy_set = '1; rdy_rand = 1'b1;
    run(300);

    // Drain and account for every word (R4)
    rdy_rand = 1'b0; rdy_set = '1;
    for (int j = 0; j < 3000; j++) begin
      bit busy = 1'b0;
      for (int i = 0; i < NPE; i++) if (remaining[i] > 0 || m_full[i]) busy = 1'b1;
      if (!busy) break;
      cycle();
    end
    for (int i = 0; i < NPE; i++)
      check(seq_rx[i] == seq_tx[i], "R4 exactly-once delivery", seq_rx[i], seq_tx[i]);
    run(2);
    check(buf_valid == '0, "R1 R4 idle after drain", int'(buf_valid), 0);
    report();
  end

endmodule